// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block takes a single block-transfer instruction and turns it into a series of one-word memory requests. The instruction says whether the transfer is a load or a store, how many words to move, the first register, the base address, and whether the base register should be updated. The block drives those requests through two internal stages. The first is an address-generation (issue) stage. The second is an execute stage, which presents each request on the memory port.

The issue stage stays occupied while earlier micro-ops move into execute, so an N-word transfer holds the block for exactly N+1 cycles. Micro-op k uses address base + 4k and register first + k. Register indices are 5 bits and wrap modulo 32. In the cycle of the last request the block pulses `done`. In that same cycle it reports the updated base (base + 4N) when an update was asked for. For loads it also reports the register written last, because later instructions depend on that result. The memory port is always ready, so requests carry no back-pressure.

The instruction input uses a valid/ready handshake, and a transfer is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is the inverse of `busy`. An offer made while busy is not taken; the upstream side must keep `in_valid` and the fields steady until it is accepted. Two-word (double) transfers are simply N=2.

Top module: `lsm_sequencer`

## Requirements
- R1: Immediately after reset, `busy`=0, `in_ready`=1, `req_valid`=0, `done`=0, `wb_valid`=0 and `dep_valid`=0.
- R2: An accepted transfer with a supported count N (1..8 or 12) produces exactly N requests in consecutive cycles. The first request appears in the second cycle after the accepting edge, and no request appears in the first.
- R3: The request address for micro-op k (k = 0..N-1) is base + 4k.
- R4: The request register index for micro-op k is (first + k) mod 32, in ascending order.
- R5: `req_we` is 1 on every request of a store (`in_is_load`=0) and 0 on every request of a load.
- R6: `busy` is high for exactly N+1 consecutive cycles, starting the cycle after acceptance, and `in_ready` equals not `busy`. An instruction offered while busy is not accepted, does not change the requests in flight, and is taken on the first edge where `busy` is low.
- R7: `done` is a one-cycle pulse in the same cycle as the last request. In the next cycle neither `req_valid` nor `done` is high.
- R8: When the update flag was set, `wb_valid` pulses together with `done` and `wb_base` = base + 4N. When the flag was clear, `wb_valid` stays 0.
- R9: For a load, `dep_valid` pulses together with `done` and `dep_reg` equals the register of the last micro-op. For a store, `dep_valid` stays 0.
- R10: An offered count outside the supported set (0, 9, 10, 11, 13, 14, 15) is consumed by the handshake but ignored. No request is made and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken (not busy) |
| in_is_load | input | 1 | 1 = load, 0 = store |
| in_count | input | 4 | Word count N |
| in_first_reg | input | 5 | First register index |
| in_base | input | 32 | Base address |
| in_update | input | 1 | Request base update |
| busy | output | 1 | Transfer in progress; stall to fetch |
| req_valid | output | 1 | Memory request this cycle |
| req_addr | output | 32 | Request word address |
| req_reg | output | 5 | Register index of this micro-op |
| req_we | output | 1 | Request is a write (store) |
| done | output | 1 | Last micro-op in execute |
| wb_valid | output | 1 | Updated base available |
| wb_base | output | 32 | Updated base value |
| dep_valid | output | 1 | Last load register reported |
| dep_reg | output | 5 | Register written by the last load micro-op |

## Verification
The two things that can fall in the same cycle are the final execute-stage request and the instruction-level results: `done`, base writeback and the last-load dependency report. The bench checks that these appear together on the last request of each table entry, and not one cycle early or late. It also checks that the last request still carries its own address and register. A second overlap comes from offering a new instruction throughout an ongoing transfer. The bench keeps `in_valid` high during a three-word store and judges two things. The store's requests must be unchanged, and the held load must start only on the edge after `busy` falls.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned REG_W      = 5;
  localparam int unsigned CNT_W      = 4;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned OFF_SH     = $clog2(WORD_BYTES);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] base;
    logic [REG_W-1:0]  regi;
    logic [CNT_W-1:0]  cnt;
    logic              we;
    logic              last;
    logic              wb;
  } uop_t;

  function automatic logic count_ok(input logic [CNT_W-1:0] n);
    return ((n >= CNT_W'(1)) && (n <= CNT_W'(8))) || (n == CNT_W'(12));
  endfunction
endpackage

// File: rtl/lsm_issue.sv
`timescale 1ns/1ps
module lsm_issue
  import lsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_load,
  input  logic [CNT_W-1:0]  acc_cnt,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [ADDR_W-1:0] acc_base,
  input  logic              acc_wb,
  output logic              ii_valid,
  output uop_t              ii_uop
);
  logic              vld_q;
  logic [CNT_W-1:0]  k_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  rs_q;
  logic [ADDR_W-1:0] base_q;
  logic              ld_q;
  logic              wb_q;
  logic              last;

  assign last = (k_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      k_q    <= '0;
      cnt_q  <= '0;
      rs_q   <= '0;
      base_q <= '0;
      ld_q   <= 1'b0;
      wb_q   <= 1'b0;
    end else if (acc) begin
      vld_q  <= 1'b1;
      k_q    <= '0;
      cnt_q  <= acc_cnt;
      rs_q   <= acc_reg;
      base_q <= acc_base;
      ld_q   <= acc_load;
      wb_q   <= acc_wb;
    end else if (vld_q) begin
      if (last) vld_q <= 1'b0;
      else      k_q   <= k_q + CNT_W'(1);
    end
  end

  always_comb begin
    ii_valid     = vld_q;
    ii_uop.addr  = base_q + (ADDR_W'(k_q) << OFF_SH);
    ii_uop.base  = base_q;
    ii_uop.regi  = rs_q + REG_W'(k_q);
    ii_uop.cnt   = cnt_q;
    ii_uop.we    = ~ld_q;
    ii_uop.last  = last;
    ii_uop.wb    = wb_q;
  end
endmodule

// File: rtl/lsm_exec.sv
`timescale 1ns/1ps
module lsm_exec
  import lsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ii_valid,
  input  uop_t              ii_uop,
  output logic              ex_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  output logic              req_we,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_base,
  output logic              dep_valid,
  output logic [REG_W-1:0]  dep_reg
);
  logic vld_q;
  uop_t uop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      uop_q <= '0;
    end else begin
      vld_q <= ii_valid;
      if (ii_valid) uop_q <= ii_uop;
    end
  end

  // ALU result for base update: base + count * word size
  always_comb begin
    ex_valid  = vld_q;
    req_addr  = uop_q.addr;
    req_reg   = uop_q.regi;
    req_we    = uop_q.we;
    done      = vld_q & uop_q.last;
    wb_valid  = vld_q & uop_q.last & uop_q.wb;
    wb_base   = uop_q.base + (ADDR_W'(uop_q.cnt) << OFF_SH);
    dep_valid = vld_q & uop_q.last & ~uop_q.we;
    dep_reg   = uop_q.regi;
  end
endmodule

// File: rtl/lsm_sequencer.sv
`timescale 1ns/1ps
module lsm_sequencer
  import lsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_load,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [REG_W-1:0]  in_first_reg,
  input  logic [ADDR_W-1:0] in_base,
  input  logic              in_update,
  output logic              busy,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  output logic              req_we,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_base,
  output logic              dep_valid,
  output logic [REG_W-1:0]  dep_reg
);
  logic acc;
  logic ii_valid;
  uop_t ii_uop;
  logic ex_valid;

  assign busy     = ii_valid | ex_valid;
  assign in_ready = ~busy;
  assign acc      = in_valid & in_ready & count_ok(in_count);
  assign req_valid = ex_valid;

  lsm_issue u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .acc_load (in_is_load),
    .acc_cnt  (in_count),
    .acc_reg  (in_first_reg),
    .acc_base (in_base),
    .acc_wb   (in_update),
    .ii_valid (ii_valid),
    .ii_uop   (ii_uop)
  );

  lsm_exec u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ii_valid  (ii_valid),
    .ii_uop    (ii_uop),
    .ex_valid  (ex_valid),
    .req_addr  (req_addr),
    .req_reg   (req_reg),
    .req_we    (req_we),
    .done      (done),
    .wb_valid  (wb_valid),
    .wb_base   (wb_base),
    .dep_valid (dep_valid),
    .dep_reg   (dep_reg)
  );
endmodule

// File: rtl/lsm_sequencer_chk.sv
`timescale 1ns/1ps
module lsm_sequencer_chk
  import lsm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CNT_W-1:0]  in_count,
  input logic              busy,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [REG_W-1:0]  req_reg,
  input logic              req_we,
  input logic              done,
  input logic              wb_valid,
  input logic              dep_valid
);
  logic take;
  assign take = in_valid && in_ready && count_ok(in_count);

  p_first_cycle_issue_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy && !req_valid);
  p_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !done) |=> req_valid);
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !done) |=> req_addr == $past(req_addr) + ADDR_W'(WORD_BYTES));
  p_reg_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !done) |=> req_reg == $past(req_reg) + REG_W'(1));
  p_dir_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !done) |=> $stable(req_we));
  p_ready_vs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  p_req_inside_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req_valid && !done);
  p_done_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_valid);
  p_wb_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);
  p_dep_load_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dep_valid |-> done && !req_we);
  p_bad_count_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !count_ok(in_count)) |=> !busy);
endmodule

bind lsm_sequencer lsm_sequencer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_count  (in_count),
  .busy      (busy),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_reg   (req_reg),
  .req_we    (req_we),
  .done      (done),
  .wb_valid  (wb_valid),
  .dep_valid (dep_valid)
);

// File: tb/lsm_sequencer_tb_top.sv
`timescale 1ns/1ps
module lsm_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_load = 1'b0;
  logic [3:0]  in_count = '0;
  logic [4:0]  in_first_reg = '0;
  logic [31:0] in_base = '0;
  logic        in_update = 1'b0;
  logic        busy, req_valid, req_we, done, wb_valid, dep_valid;
  logic [31:0] req_addr, wb_base;
  logic [4:0]  req_reg, dep_reg;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lsm_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_load(in_is_load), .in_count(in_count), .in_first_reg(in_first_reg),
    .in_base(in_base), .in_update(in_update), .busy(busy),
    .req_valid(req_valid), .req_addr(req_addr), .req_reg(req_reg),
    .req_we(req_we), .done(done), .wb_valid(wb_valid), .wb_base(wb_base),
    .dep_valid(dep_valid), .dep_reg(dep_reg)
  );

  typedef struct packed {
    logic        ld;
    logic        upd;
    logic [3:0]  n;
    logic [4:0]  rs;
    logic [31:0] base;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 4'd1,  5'd3,  32'h0000_1000},
    '{1'b0, 1'b0, 4'd1,  5'd7,  32'h0000_2040},
    '{1'b1, 1'b0, 4'd2,  5'd4,  32'h0000_3000},
    '{1'b0, 1'b1, 4'd3,  5'd0,  32'h8000_0010},
    '{1'b1, 1'b1, 4'd4,  5'd12, 32'h0000_0100},
    '{1'b0, 1'b0, 4'd5,  5'd1,  32'hFFFF_FFF0},
    '{1'b1, 1'b0, 4'd6,  5'd9,  32'h0001_0000},
    '{1'b0, 1'b1, 4'd7,  5'd16, 32'h0000_0A00},
    '{1'b1, 1'b1, 4'd8,  5'd28, 32'h0000_4000},
    '{1'b0, 1'b1, 4'd12, 5'd2,  32'h0000_5000},
    '{1'b1, 1'b1, 4'd12, 5'd24, 32'h0000_6000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic ld, input logic upd, input logic [3:0] n,
                       input logic [4:0] rs, input logic [31:0] base);
    in_valid = 1'b1; in_is_load = ld; in_update = upd;
    in_count = n; in_first_reg = rs; in_base = base;
  endtask

  task automatic run_vec(input vec_t v);
    int bcnt;
    bcnt = 0;
    @(negedge clk);
    chk(busy == 1'b0 && in_ready == 1'b1, "R6 idle before offer", {30'd0, busy, in_ready}, 32'h1);
    offer(v.ld, v.upd, v.n, v.rs, v.base);
    @(negedge clk);
    in_valid = 1'b0;
    bcnt += int'(busy);
    chk(busy == 1'b1 && req_valid == 1'b0, "R2 issue-only first cycle", {30'd0, busy, req_valid}, 32'h2);
    for (int k = 0; k < int'(v.n); k++) begin
      bit lst;
      lst = (k == int'(v.n) - 1);
      @(negedge clk);
      bcnt += int'(busy);
      chk(req_valid == 1'b1, "R2 request present", {31'd0, req_valid}, 32'h1);
      chk(req_addr == v.base + 32'(4 * k), "R3 address", req_addr, v.base + 32'(4 * k));
      chk(req_reg == v.rs + 5'(k), "R4 register", {27'd0, req_reg}, {27'd0, 5'(v.rs + 5'(k))});
      chk(req_we == ~v.ld, "R5 direction", {31'd0, req_we}, {31'd0, ~v.ld});
      chk(done == lst, "R7 done timing", {31'd0, done}, {31'd0, lst});
      chk(wb_valid == (lst && v.upd), "R8 writeback strobe", {31'd0, wb_valid}, {31'd0, lst && v.upd});
      chk(dep_valid == (lst && v.ld), "R9 dependency strobe", {31'd0, dep_valid}, {31'd0, lst && v.ld});
      if (lst && v.upd)
        chk(wb_base == v.base + 32'(4 * int'(v.n)), "R8 writeback value", wb_base, v.base + 32'(4 * int'(v.n)));
      if (lst && v.ld)
        chk(dep_reg == req_reg, "R9 last load register", {27'd0, dep_reg}, {27'd0, 5'(v.rs + 5'(k))});
    end
    @(negedge clk);
    bcnt += int'(busy);
    chk(req_valid == 1'b0 && done == 1'b0, "R7 quiet after done", {30'd0, req_valid, done}, 32'h0);
    chk(bcnt == int'(v.n) + 1, "R6 occupancy N+1", 32'(bcnt), 32'(int'(v.n) + 1));
  endtask

  initial begin
    #200us;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(busy == 0 && in_ready == 1 && req_valid == 0 && done == 0 && wb_valid == 0 && dep_valid == 0,
        "R1 reset state", {26'd0, busy, in_ready, req_valid, done, wb_valid, dep_valid}, 32'h10);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R6 offer held during a transfer is not taken until busy drops
    @(negedge clk);
    offer(1'b0, 1'b0, 4'd3, 5'd5, 32'h0000_2000);
    @(negedge clk);
    offer(1'b1, 1'b1, 4'd2, 5'd10, 32'h0000_3000);
    chk(busy == 1'b1 && in_ready == 1'b0, "R6 not ready while busy", {30'd0, busy, in_ready}, 32'h2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_addr == 32'h2000 + 32'(4 * k) && req_we == 1'b1, "R6 in-flight unaffected", req_addr, 32'h2000 + 32'(4 * k));
      chk(req_reg == 5'd5 + 5'(k), "R6 in-flight register", {27'd0, req_reg}, {27'd0, 5'd5 + 5'(k)});
    end
    @(negedge clk);
    chk(busy == 1'b0 && in_ready == 1'b1, "R6 ready after occupancy", {30'd0, busy, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy == 1'b1 && req_valid == 1'b0, "R6 held offer taken", {30'd0, busy, req_valid}, 32'h2);
    @(negedge clk);
    chk(req_valid && req_addr == 32'h3000 && req_reg == 5'd10 && !req_we, "R6 held first request", req_addr, 32'h3000);
    @(negedge clk);
    chk(req_addr == 32'h3004 && done && wb_valid && wb_base == 32'h3008, "R8 held writeback", wb_base, 32'h3008);
    chk(dep_valid && dep_reg == 5'd11, "R9 held dependency", {27'd0, dep_reg}, 32'd11);

    // R10 unsupported counts are consumed and ignored
    foreach (VEC[i]) begin end
    for (int b = 0; b < 4; b++) begin
      logic [3:0] bad;
      bad = (b == 0) ? 4'd0 : (b == 1) ? 4'd9 : (b == 2) ? 4'd11 : 4'd15;
      @(negedge clk);
      offer(1'b1, 1'b1, bad, 5'd1, 32'h0000_7000);
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk(busy == 1'b0 && req_valid == 1'b0 && done == 1'b0, "R10 unsupported count ignored",
            {29'd0, busy, req_valid, done}, 32'h0);
        @(negedge clk);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule